// File: doc/BRIEF.md
# Video Sync Routing and Clamp Controller

This block belongs to the digital front end of a video digitizer. Two horizontal sync candidates reach it: a dedicated horizontal sync pin and the output of a sync-on-green slicer. Two vertical sync candidates also reach it: a vertical sync pin and a sync-separator output. It also receives an external clamp pin, a coast pin and a set of static routing and polarity bits. For each sync type it picks the active source, either by forced selection or by watching which source toggles. It then applies output polarity, produces the clamp strobe shared by the three colour channels, and produces the coast signal for the pixel-clock PLL.

Every pin input is brought into the pixel clock domain through a two-flop synchronizer. All five outputs are registered. The clamp can come from the external pin, with selectable active level. It can instead come from an internal generator, which counts a placement delay and then a pulse length from the leading edge of the selected horizontal sync.

Top module: `sync_route_clamp`

## Requirements
- R1: While `rst_ni` is low, every output (`hs_o`, `sog_o`, `vs_o`, `clamp_o`, `coast_o`) is 0.
- R2: With `hs_force_i`=1, `hs_pick_i`=0 routes the horizontal sync pin and `hs_pick_i`=1 routes the sync-on-green input to `hs_o`, whatever the activity of either source.
- R3: With forcing off, a source counts as active when it has toggled within the last `act_win_i` pixel clocks. When exactly one of the two sources is active, that source is routed. This holds for both the horizontal and the vertical pair.
- R4: With forcing off and both horizontal sources active, `hs_pick_i` decides the source (0 = sync pin, 1 = sync-on-green).
- R5: With forcing off and neither source active, the previously routed source stays routed.
- R6: `hs_neg_i`=0 drives the sync level unchanged on `hs_o` and `sog_o`. `hs_neg_i`=1 drives both inverted.
- R7: With `vs_force_i`=1, `vs_pick_i`=0 routes the vertical sync pin and `vs_pick_i`=1 routes the sync-separator output.
- R8: `vs_pass_i`=1 passes the routed vertical sync unchanged to `vs_o`. `vs_pass_i`=0 inverts it.
- R9: `coast_from_vs_i`=0 drives `coast_o` from the coast pin. `coast_from_vs_i`=1 drives it from the routed vertical sync before the `vs_pass_i` inversion.
- R10: With `clamp_ext_i`=1, `clamp_o` follows the clamp pin. When `clamp_lowact_i`=1 the pin is active low (clamp while the pin is 0). When `clamp_lowact_i`=0 it is active high.
- R11: With `clamp_ext_i`=0, `clamp_o` rises `clamp_place_i`+1 pixel clocks after `hs_o` shows a leading (rising) edge of the routed sync at positive polarity. It stays high for exactly `clamp_len_i` clocks.
- R12: A `clamp_len_i` of 0 produces no clamp pulse.
- R13: A leading edge of the routed horizontal sync that arrives while a clamp sequence is counting restarts the sequence from its placement delay.
- R14: A level change on a pin reaches the output that passes it three pixel clock edges later (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hs_pin_i | input | 1 | Horizontal sync pin (asynchronous) |
| sog_pin_i | input | 1 | Sync-on-green slicer output (asynchronous) |
| vs_pin_i | input | 1 | Vertical sync pin (asynchronous) |
| vsep_i | input | 1 | Sync-separator vertical output (asynchronous) |
| clamp_pin_i | input | 1 | External clamp pin (asynchronous) |
| coast_pin_i | input | 1 | External coast pin (asynchronous) |
| hs_force_i | input | 1 | 1 forces horizontal source choice |
| hs_pick_i | input | 1 | Horizontal source when forced or tied: 0 pin, 1 sync-on-green |
| vs_force_i | input | 1 | 1 forces vertical source choice |
| vs_pick_i | input | 1 | Vertical source when forced or tied: 0 pin, 1 separator |
| hs_neg_i | input | 1 | 1 inverts `hs_o` and `sog_o` |
| vs_pass_i | input | 1 | 1 passes vertical sync, 0 inverts it |
| clamp_ext_i | input | 1 | 1 selects the external clamp pin, 0 the internal generator |
| clamp_lowact_i | input | 1 | 1 treats the clamp pin as active low |
| coast_from_vs_i | input | 1 | 1 takes coast from routed vertical sync |
| act_win_i | input | ACT_W | Activity window in pixel clocks |
| clamp_place_i | input | CLP_W | Clamp placement delay in pixel clocks |
| clamp_len_i | input | CLP_W | Clamp pulse length in pixel clocks |
| hs_o | output | 1 | Routed horizontal sync with polarity applied |
| sog_o | output | 1 | Sync-on-green with polarity applied |
| vs_o | output | 1 | Routed vertical sync with inversion applied |
| clamp_o | output | 1 | Clamp strobe for all three channels |
| coast_o | output | 1 | Coast request for the PLL |

## Verification
A pin level reaches its output after three pixel clock edges. The bench applies a pin change at a falling edge. It checks that the output still holds the old value two rising edges later and holds the new value after the third. The internal clamp is measured from the cycle in which `hs_o` rises: its rising edge is due placement+1 cycles later, and its high time is counted against the programmed length. Selection tests hold a pattern for several activity windows before they sample. The one-cycle delay of the registered source choice is therefore settled, and any sampling phase gives the same toggle count class.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_WAIT = 2'd1,
        CG_ON   = 2'd2
    } cg_state_e;

    typedef struct packed {
        logic hs;
        logic sog;
        logic vs;
        logic clamp;
        logic coast;
        logic hs_prev;
    } out_regs_t;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st1_d, st1_q, st2_d, st2_q;

    always_comb begin
        st1_d = d_i;
        st2_d = st1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= st1_d;
            st2_q <= st2_d;
        end
    end

    assign q_o = st2_q;
endmodule

// File: rtl/sr_act_det.sv
module sr_act_det #(
    parameter int AW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          s_i,
    input  logic [AW-1:0] win_i,
    output logic          active_o
);
    logic          prev_d, prev_q;
    logic [AW-1:0] age_d, age_q;
    logic          toggled;

    always_comb begin
        toggled = s_i ^ prev_q;
        prev_d  = s_i;
        if (toggled)
            age_d = '0;
        else if (age_q == {AW{1'b1}})
            age_d = age_q;
        else
            age_d = age_q + 1'b1;
        active_o = toggled | (age_q < win_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            age_q  <= {AW{1'b1}};
        end else begin
            prev_q <= prev_d;
            age_q  <= age_d;
        end
    end
endmodule

// File: rtl/sr_src_pick.sv
module sr_src_pick (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic force_i,
    input  logic sel_i,
    input  logic act0_i,
    input  logic act1_i,
    output logic pick_o
);
    logic pick_d, pick_q;

    always_comb begin
        pick_d = pick_q;
        if (force_i)
            pick_d = sel_i;
        else if (act0_i && act1_i)
            pick_d = sel_i;
        else if (act0_i)
            pick_d = 1'b0;
        else if (act1_i)
            pick_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pick_q <= 1'b0;
        else         pick_q <= pick_d;
    end

    assign pick_o = pick_q;

    p_forced_choice_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_i |=> (pick_q == $past(sel_i)));

    p_tie_break_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!force_i && act0_i && act1_i) |=> (pick_q == $past(sel_i)));

    p_sole_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!force_i && (act0_i != act1_i)) |=> (pick_q == $past(act1_i)));

    p_hold_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!force_i && !act0_i && !act1_i) |=> $stable(pick_q));
endmodule

// File: rtl/sr_clamp_gen.sv
module sr_clamp_gen
    import sync_route_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          trig_i,
    input  logic [CW-1:0] place_i,
    input  logic [CW-1:0] len_i,
    output logic          on_o
);
    cg_state_e     st_d, st_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (trig_i) begin
            if (len_i == '0) begin
                st_d  = CG_IDLE;
                cnt_d = '0;
            end else if (place_i == '0) begin
                st_d  = CG_ON;
                cnt_d = len_i;
            end else begin
                st_d  = CG_WAIT;
                cnt_d = place_i;
            end
        end else begin
            case (st_q)
                CG_WAIT: begin
                    if (cnt_q <= 1) begin
                        st_d  = (len_i == '0) ? CG_IDLE : CG_ON;
                        cnt_d = len_i;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                CG_ON: begin
                    if (cnt_q <= 1) begin
                        st_d  = CG_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    st_d  = CG_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= CG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign on_o = (st_q == CG_ON);

    p_zero_len_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && len_i == '0) |=> !on_o);

    p_pulse_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == CG_ON && cnt_q == 1 && !trig_i) |=> (st_q == CG_IDLE));

    p_restart_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && len_i != '0 && place_i != '0) |=> (st_q == CG_WAIT && cnt_q == $past(place_i)));
endmodule

// File: rtl/sync_route_clamp.sv
module sync_route_clamp
    import sync_route_pkg::*;
#(
    parameter int ACT_W = 12,
    parameter int CLP_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hs_pin_i,
    input  logic             sog_pin_i,
    input  logic             vs_pin_i,
    input  logic             vsep_i,
    input  logic             clamp_pin_i,
    input  logic             coast_pin_i,
    input  logic             hs_force_i,
    input  logic             hs_pick_i,
    input  logic             vs_force_i,
    input  logic             vs_pick_i,
    input  logic             hs_neg_i,
    input  logic             vs_pass_i,
    input  logic             clamp_ext_i,
    input  logic             clamp_lowact_i,
    input  logic             coast_from_vs_i,
    input  logic [ACT_W-1:0] act_win_i,
    input  logic [CLP_W-1:0] clamp_place_i,
    input  logic [CLP_W-1:0] clamp_len_i,
    output logic             hs_o,
    output logic             sog_o,
    output logic             vs_o,
    output logic             clamp_o,
    output logic             coast_o
);
    localparam int N_PINS = 6;
    localparam int N_SRC  = 4;
    localparam int N_PAIR = N_SRC / 2;

    logic [N_PINS-1:0] pins_raw, pins_s;
    logic              hs_s, sog_s, vs_s, vsep_s, clamp_s, coast_s;

    assign pins_raw = {coast_pin_i, clamp_pin_i, vsep_i, vs_pin_i, sog_pin_i, hs_pin_i};

    sr_sync #(.W(N_PINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_raw),
        .q_o    (pins_s)
    );

    assign {coast_s, clamp_s, vsep_s, vs_s, sog_s, hs_s} = pins_s;

    // activity per candidate source: index 0/1 horizontal, 2/3 vertical
    logic [N_SRC-1:0] src_s, src_act;
    assign src_s = {vsep_s, vs_s, sog_s, hs_s};

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_act
        sr_act_det #(.AW(ACT_W)) u_act (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .s_i      (src_s[gi]),
            .win_i    (act_win_i),
            .active_o (src_act[gi])
        );
    end

    logic [N_PAIR-1:0] pair_force, pair_sel, pair_pick;
    assign pair_force = {vs_force_i, hs_force_i};
    assign pair_sel   = {vs_pick_i, hs_pick_i};

    for (genvar gp = 0; gp < N_PAIR; gp++) begin : g_pick
        sr_src_pick u_pick (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .force_i (pair_force[gp]),
            .sel_i   (pair_sel[gp]),
            .act0_i  (src_act[2*gp]),
            .act1_i  (src_act[2*gp+1]),
            .pick_o  (pair_pick[gp])
        );
    end

    logic      hs_rt, vs_rt, hs_lead, gen_on;
    out_regs_t o_d, o_q;

    assign hs_rt   = pair_pick[0] ? sog_s  : hs_s;
    assign vs_rt   = pair_pick[1] ? vsep_s : vs_s;
    assign hs_lead = hs_rt & ~o_q.hs_prev;

    sr_clamp_gen #(.CW(CLP_W)) u_clamp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (hs_lead),
        .place_i (clamp_place_i),
        .len_i   (clamp_len_i),
        .on_o    (gen_on)
    );

    always_comb begin
        o_d         = o_q;
        o_d.hs      = hs_rt ^ hs_neg_i;
        o_d.sog     = sog_s ^ hs_neg_i;
        o_d.vs      = vs_rt ^ ~vs_pass_i;
        o_d.clamp   = clamp_ext_i ? (clamp_s ^ clamp_lowact_i) : gen_on;
        o_d.coast   = coast_from_vs_i ? vs_rt : coast_s;
        o_d.hs_prev = hs_rt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign hs_o    = o_q.hs;
    assign sog_o   = o_q.sog;
    assign vs_o    = o_q.vs;
    assign clamp_o = o_q.clamp;
    assign coast_o = o_q.coast;

    p_ext_clamp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clamp_ext_i) |-> (clamp_o == ($past(clamp_s) ^ $past(clamp_lowact_i))));

    p_coast_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(coast_from_vs_i) |-> (coast_o == $past(coast_s)));

    p_int_clamp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clamp_ext_i) |-> (clamp_o == $past(gen_on)));
endmodule

// File: tb/sync_route_clamp_bench.sv
module sync_route_clamp_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic hs_pin, sog_pin, vs_pin, vsep, clamp_pin, coast_pin;
    logic hs_force, hs_pick, vs_force, vs_pick, hs_neg, vs_pass;
    logic clamp_ext, clamp_lowact, coast_from_vs;
    logic [11:0] act_win;
    logic [7:0]  clamp_place, clamp_len;
    logic hs_o, sog_o, vs_o, clamp_o, coast_o;

    sync_route_clamp u_sync_route_clamp (
        .clk_i(clk), .rst_ni(rst_n),
        .hs_pin_i(hs_pin), .sog_pin_i(sog_pin), .vs_pin_i(vs_pin), .vsep_i(vsep),
        .clamp_pin_i(clamp_pin), .coast_pin_i(coast_pin),
        .hs_force_i(hs_force), .hs_pick_i(hs_pick), .vs_force_i(vs_force), .vs_pick_i(vs_pick),
        .hs_neg_i(hs_neg), .vs_pass_i(vs_pass), .clamp_ext_i(clamp_ext),
        .clamp_lowact_i(clamp_lowact), .coast_from_vs_i(coast_from_vs),
        .act_win_i(act_win), .clamp_place_i(clamp_place), .clamp_len_i(clamp_len),
        .hs_o(hs_o), .sog_o(sog_o), .vs_o(vs_o), .clamp_o(clamp_o), .coast_o(coast_o)
    );

    // pattern modes: 0 low, 1 high, 2 square wave with the given half period
    int hs_m = 0, hs_h = 1, sog_m = 0, sog_h = 1, vs_m = 0, vs_h = 1, vsep_m = 0, vsep_h = 1;
    logic clamp_v = 1'b0, coast_v = 1'b0;
    int cyc = 0;

    // scoreboard
    string tag_q[$];
    int    exp_q[$];
    int    obs_val;
    event  obs_ev;
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    initial forever begin
        string t;
        int    e;
        @(obs_ev);
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        n_chk++;
        if (obs_val != e) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", t, obs_val, e);
        end
    end

    task automatic push_check(input string tag, input int act, input int exp);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        obs_val = act;
        -> obs_ev;
        #1;
    endtask

    function automatic logic pat(input int m, input int h, input int c);
        if (m == 2) return logic'((c / h) % 2);
        return logic'(m[0]);
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        hs_pin    = pat(hs_m, hs_h, cyc);
        sog_pin   = pat(sog_m, sog_h, cyc);
        vs_pin    = pat(vs_m, vs_h, cyc);
        vsep      = pat(vsep_m, vsep_h, cyc);
        clamp_pin = clamp_v;
        coast_pin = coast_v;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // which: 0 hs_o, 1 vs_o; counts level changes over n samples
    task automatic toggles(input int which, input int n, output int tr);
        logic prev, cur;
        tr = 0;
        step();
        prev = (which == 0) ? hs_o : vs_o;
        for (int i = 0; i < n; i++) begin
            step();
            cur = (which == 0) ? hs_o : vs_o;
            if (cur != prev) tr++;
            prev = cur;
        end
    endtask

    // one pulse on hs pin (2 cycles high), then measure clamp relative to hs_o rise
    task automatic clamp_measure(input int tail, output int delay, output int width);
        int hs_at, cl_at;
        logic hs_prev, cl_prev;
        hs_at = -1; cl_at = -1; width = 0;
        hs_prev = hs_o; cl_prev = clamp_o;
        hs_m = 1; step(); step(); hs_m = 0;
        for (int i = 0; i < tail; i++) begin
            step();
            if (hs_o && !hs_prev && hs_at < 0) hs_at = i;
            if (clamp_o && !cl_prev && cl_at < 0) cl_at = i;
            if (clamp_o) width++;
            hs_prev = hs_o; cl_prev = clamp_o;
        end
        delay = (hs_at < 0 || cl_at < 0) ? -1 : cl_at - hs_at;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int tr, dly, wid, highs;
        hs_pin = 0; sog_pin = 0; vs_pin = 0; vsep = 0; clamp_pin = 0; coast_pin = 0;
        hs_force = 1; hs_pick = 0; vs_force = 1; vs_pick = 0;
        hs_neg = 0; vs_pass = 1; clamp_ext = 0; clamp_lowact = 1; coast_from_vs = 0;
        act_win = 12'd8; clamp_place = 8'd3; clamp_len = 8'd5;

        // R1: drive every pin high during reset; outputs stay low
        hs_m = 1; sog_m = 1; vs_m = 1; vsep_m = 1; coast_v = 1;
        steps(6);
        push_check("R1 outputs in reset", {hs_o, sog_o, vs_o, clamp_o, coast_o}, 0);
        rst_n = 1'b1;
        hs_m = 0; sog_m = 0; vs_m = 0; vsep_m = 0; coast_v = 0;
        steps(6);

        // R14: coast pin latency of three edges
        coast_v = 1; step();
        steps(2);
        push_check("R14 coast before third edge", coast_o, 0);
        step();
        push_check("R14 coast at third edge", coast_o, 1);
        coast_v = 0; steps(5);

        // R2: forced horizontal choice, sources at opposite levels
        hs_m = 0; sog_m = 1; hs_pick = 0; steps(6);
        push_check("R2 forced pin", hs_o, 0);
        hs_pick = 1; steps(6);
        push_check("R2 forced sog", hs_o, 1);
        // R2: forced choice overrides activity (sog toggles, pin forced)
        hs_pick = 0; hs_m = 1; sog_m = 2; sog_h = 3; steps(10);
        toggles(0, 16, tr);
        push_check("R2 forced pin ignores active sog", tr, 0);

        // R6: polarity on hs_o and sog_o
        sog_m = 1; hs_m = 1; steps(6);
        push_check("R6 hs positive", hs_o, 1);
        push_check("R6 sog positive", sog_o, 1);
        hs_neg = 1; steps(3);
        push_check("R6 hs negative", hs_o, 0);
        push_check("R6 sog negative", sog_o, 0);
        hs_neg = 0; steps(3);

        // R3: automatic, only pin active (sog held high)
        hs_force = 0; hs_pick = 1; hs_m = 2; hs_h = 3; sog_m = 1; steps(20);
        toggles(0, 16, tr);
        push_check("R3 only pin active routes pin", (tr >= 2) ? 1 : 0, 1);
        // R3: only sog active (pin held low)
        hs_pick = 0; hs_m = 0; sog_m = 2; sog_h = 3; steps(20);
        toggles(0, 16, tr);
        push_check("R3 only sog active routes sog", (tr >= 2) ? 1 : 0, 1);
        // R5: both quiet, previous choice (sog) held
        sog_m = 1; hs_m = 0; steps(30);
        push_check("R5 quiet sources hold sog", hs_o, 1);

        // R4: both active, pick bit breaks tie (pin fast, sog slow)
        hs_m = 2; hs_h = 2; sog_m = 2; sog_h = 4; hs_pick = 0; steps(20);
        toggles(0, 16, tr);
        push_check("R4 tie routes pin", (tr >= 6) ? 1 : 0, 1);
        hs_pick = 1; steps(10);
        toggles(0, 16, tr);
        push_check("R4 tie routes sog", (tr >= 6) ? 1 : 0, 0);
        hs_m = 0; sog_m = 0; hs_force = 1; hs_pick = 0; steps(30);

        // R7 / R8: forced vertical choice and inversion
        vs_m = 0; vsep_m = 1; vs_force = 1; vs_pick = 1; vs_pass = 1; steps(6);
        push_check("R7 forced separator", vs_o, 1);
        vs_pick = 0; steps(6);
        push_check("R7 forced pin", vs_o, 0);
        vs_pass = 0; steps(4);
        push_check("R8 inverted vs", vs_o, 1);
        // R3 on vertical pair: only separator active
        vs_force = 0; vs_pick = 0; vs_pass = 1; vs_m = 1; vsep_m = 2; vsep_h = 3; steps(20);
        toggles(1, 16, tr);
        push_check("R3 vertical only separator active", (tr >= 2) ? 1 : 0, 1);
        vsep_m = 1; vs_force = 1; vs_pick = 1; steps(10);

        // R9: coast from routed vertical sync, ahead of inversion
        vs_pass = 0; coast_v = 0; coast_from_vs = 1; steps(6);
        push_check("R9 coast from routed vs", coast_o, 1);
        push_check("R8 vs inverted while coast plain", vs_o, 0);
        coast_from_vs = 0; coast_v = 1; vsep_m = 0; steps(6);
        push_check("R9 coast from pin", coast_o, 1);
        coast_v = 0; vs_pass = 1; steps(6);

        // R10: external clamp and its polarity
        clamp_ext = 1; clamp_lowact = 1; clamp_v = 0; steps(6);
        push_check("R10 low-active pin low", clamp_o, 1);
        clamp_v = 1; steps(6);
        push_check("R10 low-active pin high", clamp_o, 0);
        clamp_lowact = 0; steps(3);
        push_check("R10 high-active pin high", clamp_o, 1);
        clamp_ext = 0; clamp_v = 0; steps(10);

        // R11: internal clamp timing
        clamp_place = 8'd3; clamp_len = 8'd5;
        clamp_measure(30, dly, wid);
        push_check("R11 clamp delay place 3", dly, 4);
        push_check("R11 clamp width len 5", wid, 5);
        clamp_place = 8'd0; clamp_len = 8'd2;
        clamp_measure(20, dly, wid);
        push_check("R11 clamp delay place 0", dly, 1);
        push_check("R11 clamp width len 2", wid, 2);

        // R12: zero length gives no pulse
        clamp_place = 8'd2; clamp_len = 8'd0;
        clamp_measure(30, dly, wid);
        push_check("R12 no clamp for zero length", wid, 0);

        // R13: edges every 20 cycles restart a 30-cycle placement
        clamp_place = 8'd30; clamp_len = 8'd5;
        highs = 0;
        for (int p = 0; p < 5; p++) begin
            hs_m = 1; step(); if (clamp_o) highs++;
            step(); if (clamp_o) highs++;
            hs_m = 0;
            for (int i = 0; i < 18; i++) begin step(); if (clamp_o) highs++; end
        end
        push_check("R13 retrigger suppresses clamp", highs, 0);
        highs = 0;
        for (int i = 0; i < 40; i++) begin step(); if (clamp_o) highs++; end
        push_check("R13 single pulse after last edge", highs, 5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule